// File: doc/BRIEF.md
# DMA Source Address Sequencer

This block holds the source address of one DMA channel and moves it after every transfer unit. A two-bit update mode holds the address, counts it up or counts it down. The step is one for byte units and two for word units. When the source is an external device that answers with an acknowledge in single-address mode, the block ignores the update mode and holds the address.

The address can be kept inside a power-of-two repeat area of 2^N bytes. The bits above N keep the value they were loaded with, and only the low N bits count and wrap. When the repeat interrupt is enabled, a wrap across the area boundary ends the transfer. The channel-active bit drops and the interrupt-request flag rises. In block mode that stop waits for the block-end unit. Setting the channel active again resumes from the saved address. The CPU interrupt is the request flag gated by the channel interrupt enable.

Top module: `dma_src_addr_seq`

## Requirements
- R1: After synchronous reset, addr is 0, active is 0, irq_flag is 0 and cpu_irq is 0.
- R2: A cycle with load high makes addr equal load_addr on the next cycle, and clears any deferred stop. A unit_done in the same cycle is ignored.
- R3: With upd_mode 2'b00 or 2'b01 an accepted transfer unit leaves addr unchanged.
- R4: With upd_mode 2'b10 an accepted unit adds 1 to addr when word_sz is 0 and adds 2 when word_sz is 1.
- R5: With upd_mode 2'b11 an accepted unit subtracts 1 (word_sz 0) or 2 (word_sz 1) from addr.
- R6: When ack_single_src is 1, an accepted unit leaves addr unchanged whatever upd_mode holds.
- R7: unit_done has no effect on addr, active or irq_flag while active is 0.
- R8: When rpt_log2 is N (N from 1 to 2^RW-1, below AW), addr bits N and up keep their value across units. Bits below N count modulo 2^N.
- R9: In non-block mode, a unit whose low bits wrap while rpt_irq_en is 1 clears active and sets irq_flag on the same edge that updates addr.
- R10: With rpt_irq_en 0 a wrap only folds the low bits. active stays 1 and irq_flag stays 0.
- R11: In block mode the stop caused by a wrap is deferred to the next accepted unit with blk_end high, or taken at once if the wrapping unit itself has blk_end high.
- R12: cpu_irq is 1 exactly when irq_flag is 1 and ch_irq_en is 1.
- R13: act_set makes active 1 and irq_flag 0 on the next cycle and leaves addr at its saved value.
- R14: When rpt_log2 is 0 no repeat area exists. addr wraps over its full width and rpt_irq_en never stops the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Load start address |
| load_addr | input | AW | Start address |
| upd_mode | input | 2 | Update mode: 0x hold, 10 up, 11 down |
| word_sz | input | 1 | 1 for word units, 0 for byte units |
| rpt_log2 | input | RW | Repeat area size as log2 bytes, 0 for no area |
| rpt_irq_en | input | 1 | Stop the channel on repeat-area wrap |
| blk_mode | input | 1 | Block transfer mode |
| blk_end | input | 1 | Current unit is the last of its block |
| ack_single_src | input | 1 | Source is an acknowledge-driven device in single-address mode |
| ch_irq_en | input | 1 | Channel interrupt enable |
| act_set | input | 1 | Set channel active, clear request flag |
| unit_done | input | 1 | One transfer unit finished |
| addr | output | AW | Current source address |
| active | output | 1 | Channel-active bit |
| irq_flag | output | 1 | Interrupt-request flag |
| cpu_irq | output | 1 | Interrupt to the CPU |

## Verification
addr, active and irq_flag are registers. Each one shows the effect of a stimulus on the first rising edge after it. cpu_irq is a gate on the registered flag and on ch_irq_en, so it follows ch_irq_en in the same cycle. The bench drives inputs on the falling edge. It advances a reference model by one step per rising edge and compares every output on the following falling edge, one edge after the stimulus. Deferred block stops are checked on the exact blk_end unit, not the wrapping unit.

// File: rtl/dsas_pkg.sv
package dsas_pkg;
  typedef enum logic [1:0] {
    UPD_HOLD0 = 2'b00,
    UPD_HOLD1 = 2'b01,
    UPD_UP    = 2'b10,
    UPD_DOWN  = 2'b11
  } upd_mode_t;
endpackage

// File: rtl/dsas_next.sv
module dsas_next
  import dsas_pkg::*;
#(
  parameter int AW = 16,
  parameter int RW = 4
) (
  input  logic [AW-1:0] cur,
  input  logic [1:0]    upd_mode,
  input  logic          word_sz,
  input  logic          ack_single_src,
  input  logic [RW-1:0] rpt_log2,
  output logic [AW-1:0] nxt,
  output logic [AW-1:0] area_mask,
  output logic          area_on,
  output logic          wrap
);
  logic [AW-1:0] delta, full, low;
  logic          moving, up, wrap_raw;
  upd_mode_t     md;

  always_comb begin
    md        = upd_mode_t'(upd_mode);
    area_on   = (rpt_log2 != '0);
    area_mask = (AW'(1) << rpt_log2) - AW'(1);
    delta     = word_sz ? AW'(2) : AW'(1);
    moving    = ((md == UPD_UP) || (md == UPD_DOWN)) && !ack_single_src;
    up        = (md == UPD_UP);
    full      = up ? (cur + delta) : (cur - delta);
    low       = cur & area_mask;
    wrap_raw  = up ? ((low + delta) > area_mask) : (low < delta);
    wrap      = moving && area_on && wrap_raw;
    if (!moving)
      nxt = cur;
    else if (area_on)
      nxt = (cur & ~area_mask) | (full & area_mask);
    else
      nxt = full;
  end
endmodule

// File: rtl/dsas_ctrl.sv
module dsas_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic act_set,
  input  logic go,
  input  logic wrap,
  input  logic rpt_irq_en,
  input  logic blk_mode,
  input  logic blk_end,
  output logic active,
  output logic irq_flag
);
  logic pend;
  logic wrap_int, stop;

  always_comb begin
    wrap_int = go && wrap && rpt_irq_en;
    stop     = blk_mode ? (go && blk_end && (pend || wrap_int)) : wrap_int;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      irq_flag <= 1'b0;
      pend     <= 1'b0;
    end else begin
      if (load || stop)
        pend <= 1'b0;
      else if (wrap_int && blk_mode)
        pend <= 1'b1;
      if (act_set) begin
        active   <= 1'b1;
        irq_flag <= 1'b0;
      end else if (stop) begin
        active   <= 1'b0;
        irq_flag <= 1'b1;
      end
    end
  end

  assert_stop_flags_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> irq_flag);
  assert_resume_R13: assert property (@(posedge clk) disable iff (rst)
    act_set |=> (active && !irq_flag));
  assert_no_stop_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!active && !act_set) |=> (!active && $stable(irq_flag)));
endmodule

// File: rtl/dma_src_addr_seq.sv
module dma_src_addr_seq #(
  parameter int AW = 16,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [1:0]    upd_mode,
  input  logic          word_sz,
  input  logic [RW-1:0] rpt_log2,
  input  logic          rpt_irq_en,
  input  logic          blk_mode,
  input  logic          blk_end,
  input  logic          ack_single_src,
  input  logic          ch_irq_en,
  input  logic          act_set,
  input  logic          unit_done,
  output logic [AW-1:0] addr,
  output logic          active,
  output logic          irq_flag,
  output logic          cpu_irq
);
  logic [AW-1:0] nxt, area_mask;
  logic          area_on, wrap, go;

  assign go = unit_done && active && !load;

  dsas_next #(.AW(AW), .RW(RW)) u_next (
    .cur(addr), .upd_mode(upd_mode), .word_sz(word_sz),
    .ack_single_src(ack_single_src), .rpt_log2(rpt_log2),
    .nxt(nxt), .area_mask(area_mask), .area_on(area_on), .wrap(wrap)
  );

  dsas_ctrl u_ctrl (
    .clk(clk), .rst(rst), .load(load), .act_set(act_set), .go(go),
    .wrap(wrap), .rpt_irq_en(rpt_irq_en), .blk_mode(blk_mode),
    .blk_end(blk_end), .active(active), .irq_flag(irq_flag)
  );

  always_ff @(posedge clk) begin
    if (rst)
      addr <= '0;
    else if (load)
      addr <= load_addr;
    else if (go)
      addr <= nxt;
  end

  assign cpu_irq = irq_flag & ch_irq_en;

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!active && !load) |=> $stable(addr));
  assert_fixed_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (unit_done && active && !load && !upd_mode[1]) |=> $stable(addr));
  assert_ack_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (unit_done && active && !load && ack_single_src) |=> $stable(addr));
  assert_upper_kept_R8: assert property (@(posedge clk) disable iff (rst)
    (go && area_on) |=> (((addr ^ $past(addr)) & ~$past(area_mask)) == '0));
  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (addr == $past(load_addr)));
endmodule

// File: tb/sim_dma_src_addr_seq.sv
module sim_dma_src_addr_seq;
  localparam int AW = 16;
  localparam int RW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic load = 0, word_sz = 0, rpt_irq_en = 0, blk_mode = 0, blk_end = 0;
  logic ack_single_src = 0, ch_irq_en = 0, act_set = 0, unit_done = 0;
  logic [AW-1:0] load_addr = '0;
  logic [1:0] upd_mode = '0;
  logic [RW-1:0] rpt_log2 = '0;
  logic [AW-1:0] addr;
  logic active, irq_flag, cpu_irq;

  int vecs = 0, errs = 0;
  bit done = 0;
  int m_addr; bit m_act, m_flag, m_pend;

  always #5 clk = ~clk;

  dma_src_addr_seq #(.AW(AW), .RW(RW)) u0 (
    .clk(clk), .rst(rst), .load(load), .load_addr(load_addr), .upd_mode(upd_mode),
    .word_sz(word_sz), .rpt_log2(rpt_log2), .rpt_irq_en(rpt_irq_en),
    .blk_mode(blk_mode), .blk_end(blk_end), .ack_single_src(ack_single_src),
    .ch_irq_en(ch_irq_en), .act_set(act_set), .unit_done(unit_done),
    .addr(addr), .active(active), .irq_flag(irq_flag), .cpu_irq(cpu_irq)
  );

  function automatic int step_addr(int a, output bit w);
    int d, msk, lo, nl, full;
    w = 0;
    if (upd_mode[1] == 1'b0 || ack_single_src) return a;
    d = word_sz ? 2 : 1;
    full = upd_mode[0] ? (a - d) : (a + d);
    if (rpt_log2 == 0) return full & 16'hFFFF;
    msk = (1 << rpt_log2) - 1;
    lo = a & msk;
    if (upd_mode[0]) begin nl = lo - d; w = (lo < d); end
    else begin nl = lo + d; w = (nl > msk); end
    return (a & ~msk & 16'hFFFF) | (nl & msk);
  endfunction

  task automatic model_step();
    bit w, go, wi, stp;
    int na;
    go = unit_done && m_act && !load;
    na = step_addr(m_addr, w);
    wi = go && w && rpt_irq_en;
    stp = blk_mode ? (go && blk_end && (m_pend || wi)) : wi;
    if (load) m_addr = load_addr;
    else if (go) m_addr = na;
    if (load || stp) m_pend = 0;
    else if (wi && blk_mode) m_pend = 1;
    if (act_set) begin m_act = 1; m_flag = 0; end
    else if (stp) begin m_act = 0; m_flag = 1; end
  endtask

  task automatic compare(string tag);
    vecs++;
    if (addr !== AW'(m_addr)) begin errs++;
      $display("FAIL %s addr: got %h exp %h", tag, addr, AW'(m_addr)); end
    if (active !== m_act) begin errs++;
      $display("FAIL %s active: got %b exp %b", tag, active, m_act); end
    if (irq_flag !== m_flag) begin errs++;
      $display("FAIL %s irq_flag: got %b exp %b", tag, irq_flag, m_flag); end
    if (cpu_irq !== (m_flag & ch_irq_en)) begin errs++;
      $display("FAIL %s cpu_irq: got %b exp %b", tag, cpu_irq, m_flag & ch_irq_en); end
  endtask

  task automatic tick(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    load = 0; act_set = 0; unit_done = 0;
  endtask

  task automatic unit(string tag, logic [1:0] md, logic wd);
    upd_mode = md; word_sz = wd; unit_done = 1; tick(tag);
  endtask

  task automatic ld(string tag, int a);
    load = 1; load_addr = AW'(a); tick(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errs++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    m_addr = 0; m_act = 0; m_flag = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    compare("R1 reset");
    ld("R2 load", 16'h1234);
    unit("R7 idle step", 2'b10, 0);
    act_set = 1; tick("R13 set active");
    unit("R4 up byte", 2'b10, 0);
    unit("R4 up byte", 2'b10, 0);
    unit("R4 up word", 2'b10, 1);
    unit("R5 down byte", 2'b11, 0);
    unit("R5 down word", 2'b11, 1);
    unit("R3 hold 00", 2'b00, 1);
    unit("R3 hold 01", 2'b01, 0);
    ack_single_src = 1; unit("R6 ack hold", 2'b10, 1); ack_single_src = 0;
    load = 1; load_addr = 16'h5555; unit_done = 1; tick("R2 load beats unit");
    rpt_log2 = 4; rpt_irq_en = 0;
    ld("R8 load", 16'h12FE);
    unit("R10 wrap no irq", 2'b10, 1);
    ld("R8 load dn", 16'h1230);
    unit("R8 down wrap", 2'b11, 0);
    rpt_irq_en = 1;
    ld("R9 load", 16'h12FE);
    ch_irq_en = 0;
    unit("R9 wrap stops", 2'b10, 1);
    ch_irq_en = 1; #1; compare("R12 irq gated on");
    ch_irq_en = 0; #1; compare("R12 irq gated off");
    act_set = 1; tick("R13 resume");
    blk_mode = 1;
    ld("R11 load", 16'h12FF);
    unit("R11 wrap deferred", 2'b10, 0);
    unit("R11 still running", 2'b10, 0);
    blk_end = 1; unit("R11 block end stop", 2'b10, 0); blk_end = 0;
    blk_mode = 0;
    rpt_log2 = 0; rpt_irq_en = 1; act_set = 1; tick("R14 restart");
    ld("R14 load", 16'hFFFF);
    unit("R14 full wrap", 2'b10, 0);
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      load = ($urandom % 16) == 0;
      load_addr = AW'($urandom);
      act_set = ($urandom % 12) == 0;
      unit_done = ($urandom % 4) != 0;
      upd_mode = 2'($urandom);
      word_sz = 1'($urandom);
      rpt_log2 = RW'($urandom % 8);
      rpt_irq_en = 1'($urandom);
      blk_mode = ($urandom % 3) == 0;
      blk_end = ($urandom % 4) == 0;
      ack_single_src = ($urandom % 8) == 0;
      ch_irq_en = 1'($urandom);
      tick("RND");
    end
    finish_run();
  end
endmodule